// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Sequencer

This block sits between the PWM modulator and the gate drivers of a synchronous buck converter. It takes the modulator's high-side and low-side gate requests and applies a cycle-by-cycle current-limit override. When the high-side overcurrent comparator fires, the high-side request is cut for the rest of the switching period. The low-side switch is then forced on until the low-side comparator reports that the inductor current has fallen below its limit.

A short-circuit detector watches for current limiting that persists while feedback sits below 70% of the reference. If both hold without a break for a blanking window (counted in ticks of an external timer), the block enters hiccup. In hiccup both switches are held off and discharge requests pull down the compensation node and the reference/soft-start node. This off window lasts a fixed number of switching-clock strobes. A restart window follows, during which switching resumes and short-circuit detection is blanked. At the end of the restart window the block either returns to normal operation or goes back to the off window, depending on whether the fault is still present.

Enable low parks the block in an idle state with both gates off.

Top module: `hiccup_seq`

## Requirements
- R1: While the block is switching (run or restart state), a high `oc_hs` forces `gate_hs` low and `gate_ls` high in the same cycle, whatever the PWM requests are.
- R2: After a cycle in which `oc_hs` was high, `gate_hs` stays low even when `oc_hs` has dropped and the low-side hold has ended, until a `sw_strobe` has been sampled.
- R3: After a current-limit event, `gate_ls` stays high while `ls_over` is high; one clock after `ls_over` is sampled low, `gate_ls` follows `pwm_ls` again.
- R4: In the run state, hiccup is entered on the clock edge that samples the `BLANK_TICKS`-th `blank_tick`, counted while current limiting is active and `fb_low` is high without a break; after `BLANK_TICKS`-1 such ticks `hiccup` is still low.
- R5: Tick counting starts over whenever `fb_low` is sampled low or current limiting ends.
- R6: In the hiccup off state, `gate_hs` and `gate_ls` are low and `comp_dis`, `ref_dis` and `hiccup` are high.
- R7: The off state ends on the edge that samples its `OFF_CYCLES`-th `sw_strobe`. The block then enters the restart state: `comp_dis` and `ref_dis` low, `hiccup` high.
- R8: The restart state lasts exactly `RESTART_CYCLES` strobes, and no number of blanking ticks under fault conditions ends it early.
- R9: On the closing strobe of the restart state, the block returns to the off state if current limiting is active and `fb_low` is high; otherwise it returns to run with `hiccup` low.
- R10: `enable` low moves the block from any state to idle on the next edge. In idle, gates are low, `hiccup` is low, the discharge requests are high, and any current-limit hold and counter are cleared. `enable` high moves the block from idle to run on the next edge.
- R11: In run with no current-limit event pending, `gate_hs` follows `pwm_hs` and `gate_ls` follows `pwm_ls`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable |
| oc_hs | input | 1 | High-side peak current above limit |
| ls_over | input | 1 | Low-side current still above low-side limit |
| fb_low | input | 1 | Feedback below 70% of reference |
| blank_tick | input | 1 | One-cycle tick of the blanking timebase |
| sw_strobe | input | 1 | One-cycle strobe at each switching period start |
| pwm_hs | input | 1 | High-side gate request from the modulator |
| pwm_ls | input | 1 | Low-side gate request from the modulator |
| gate_hs | output | 1 | High-side gate command |
| gate_ls | output | 1 | Low-side gate command |
| comp_dis | output | 1 | Discharge request for the compensation node |
| ref_dis | output | 1 | Discharge request for the reference/soft-start node |
| hiccup | output | 1 | High in the hiccup off and restart states |

## Verification
The override is exercised by pulsing `oc_hs` with `ls_over` held high and then with `ls_over` released. This separates the low-side hold (R3) from the high-side blocking that lasts until the next strobe (R2).

The detector is fed runs of ticks that stop one short of the window, that are broken by a one-cycle `fb_low` gap, and that complete. This checks the boundary count and the restart of counting.

The restart window is tried once with a persisting fault and a surplus of ticks, which must return the block to the off state only on the final strobe. It is tried once with clean inputs, which must return the block to run.

Enable is dropped both during a held low-side override and during the off window, to show the return to idle and the release of the override.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_RUN   = 2'd1,
    HS_OFF   = 2'd2,
    HS_RETRY = 2'd3
  } hic_state_t;

endpackage

// File: rtl/hic_limiter.sv
module hic_limiter (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic sw_strobe,
  input  logic oc_hs,
  input  logic ls_over,
  input  logic pwm_hs,
  input  logic pwm_ls,
  output logic gate_hs,
  output logic gate_ls,
  output logic limit_act
);

  logic hs_blk_q, hs_blk_d;
  logic ls_hold_q, ls_hold_d;

  always_comb begin
    hs_blk_d  = hs_blk_q;
    ls_hold_d = ls_hold_q;
    if (!run_en) begin
      hs_blk_d  = 1'b0;
      ls_hold_d = 1'b0;
    end else begin
      if (oc_hs)          hs_blk_d = 1'b1;
      else if (sw_strobe) hs_blk_d = 1'b0;
      if (oc_hs)          ls_hold_d = 1'b1;
      else if (!ls_over)  ls_hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_blk_q  <= 1'b0;
      ls_hold_q <= 1'b0;
    end else begin
      hs_blk_q  <= hs_blk_d;
      ls_hold_q <= ls_hold_d;
    end
  end

  assign gate_hs   = run_en & pwm_hs & ~oc_hs & ~hs_blk_q & ~ls_hold_q;
  assign gate_ls   = run_en & (oc_hs | ls_hold_q | (pwm_ls & ~gate_hs));
  assign limit_act = hs_blk_q | ls_hold_q;

  // R1
  oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && oc_hs) |-> (!gate_hs && gate_ls));

  // R1
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs && gate_ls));

  // R2
  hs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && oc_hs) |=> !gate_hs);

endmodule

// File: rtl/hic_detect.sv
module hic_detect #(
  parameter int BLANK_TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic limit_act,
  input  logic fb_low,
  input  logic blank_tick,
  output logic trip
);

  localparam int CW = $clog2(BLANK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual;

  assign qual = arm & limit_act & fb_low;
  assign trip = qual & blank_tick & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!qual)
      cnt_d = '0;
    else if (blank_tick && cnt_q != LAST)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  blank_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_low |=> (cnt_q == '0));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/hic_fsm.sv
module hic_fsm
  import hiccup_pkg::*;
#(
  parameter int OFF_CYCLES     = 896,
  parameter int RESTART_CYCLES = 112
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sw_strobe,
  input  logic       trip,
  input  logic       fault_now,
  output hic_state_t state
);

  localparam int MAXC = (OFF_CYCLES > RESTART_CYCLES) ? OFF_CYCLES : RESTART_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RESTART_CYCLES - 1);

  hic_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!enable) begin
      state_d = HS_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          state_d = HS_RUN;
          cnt_d   = '0;
        end
        HS_RUN: begin
          if (trip) begin
            state_d = HS_OFF;
            cnt_d   = '0;
          end
        end
        HS_OFF: begin
          if (sw_strobe) begin
            if (cnt_q == OFF_LAST) begin
              state_d = HS_RETRY;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        HS_RETRY: begin
          if (sw_strobe) begin
            if (cnt_q == RST_LAST) begin
              state_d = fault_now ? HS_OFF : HS_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_d = HS_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

  // R7
  off_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_OFF) |-> (cnt_q <= OFF_LAST));

  // R8
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RETRY && enable && !(sw_strobe && cnt_q == RST_LAST))
      |=> (state_q == HS_RETRY));

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && !trip) |=> (state_q != HS_OFF));

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_pkg::*;
#(
  parameter int BLANK_TICKS    = 12,
  parameter int OFF_CYCLES     = 896,
  parameter int RESTART_CYCLES = 112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic oc_hs,
  input  logic ls_over,
  input  logic fb_low,
  input  logic blank_tick,
  input  logic sw_strobe,
  input  logic pwm_hs,
  input  logic pwm_ls,
  output logic gate_hs,
  output logic gate_ls,
  output logic comp_dis,
  output logic ref_dis,
  output logic hiccup
);

  hic_state_t state;
  logic       run_en;
  logic       arm;
  logic       limit_act;
  logic       trip;
  logic       fault_now;

  assign run_en    = (state == HS_RUN) || (state == HS_RETRY);
  assign arm       = (state == HS_RUN);
  assign fault_now = limit_act & fb_low;

  hic_limiter u_limiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .sw_strobe (sw_strobe),
    .oc_hs     (oc_hs),
    .ls_over   (ls_over),
    .pwm_hs    (pwm_hs),
    .pwm_ls    (pwm_ls),
    .gate_hs   (gate_hs),
    .gate_ls   (gate_ls),
    .limit_act (limit_act)
  );

  hic_detect #(.BLANK_TICKS(BLANK_TICKS)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .limit_act  (limit_act),
    .fb_low     (fb_low),
    .blank_tick (blank_tick),
    .trip       (trip)
  );

  hic_fsm #(.OFF_CYCLES(OFF_CYCLES), .RESTART_CYCLES(RESTART_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sw_strobe (sw_strobe),
    .trip      (trip),
    .fault_now (fault_now),
    .state     (state)
  );

  assign hiccup   = (state == HS_OFF) || (state == HS_RETRY);
  assign comp_dis = (state == HS_OFF) || (state == HS_IDLE);
  assign ref_dis  = comp_dis;

  // R6
  off_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hiccup && comp_dis) |-> (!gate_hs && !gate_ls));

  // R10
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hiccup && comp_dis && !gate_hs && !gate_ls));

endmodule

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;

  localparam int BLANK = 12;
  localparam int OFFC  = 896;
  localparam int RSTC  = 112;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, oc_hs, ls_over, fb_low, blank_tick, sw_strobe, pwm_hs, pwm_ls;
  logic gate_hs, gate_ls, comp_dis, ref_dis, hiccup;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hiccup_seq #(.BLANK_TICKS(BLANK), .OFF_CYCLES(OFFC), .RESTART_CYCLES(RSTC)) i_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .oc_hs(oc_hs), .ls_over(ls_over),
    .fb_low(fb_low), .blank_tick(blank_tick), .sw_strobe(sw_strobe),
    .pwm_hs(pwm_hs), .pwm_ls(pwm_ls), .gate_hs(gate_hs), .gate_ls(gate_ls),
    .comp_dis(comp_dis), .ref_dis(ref_dis), .hiccup(hiccup)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      blank_tick = 1'b1; step(); blank_tick = 1'b0;
    end
    #1;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      sw_strobe = 1'b1; step(); sw_strobe = 1'b0;
    end
    #1;
  endtask

  task automatic oc_pulse();
    oc_hs = 1'b1; step(); oc_hs = 1'b0; #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; oc_hs = 1'b0; ls_over = 1'b0; fb_low = 1'b0;
    blank_tick = 1'b0; sw_strobe = 1'b0; pwm_hs = 1'b0; pwm_ls = 1'b0;
    step(); step(); rst_n = 1'b1; step(); #1;
    chk("R10", "idle hiccup", hiccup, 1'b0);
    chk("R10", "idle comp_dis", comp_dis, 1'b1);
    chk("R10", "idle ref_dis", ref_dis, 1'b1);
    chk("R10", "idle gate_ls", gate_ls, 1'b0);
  endtask

  task automatic t_run();
    enable = 1'b1; step();
    pwm_hs = 1'b1; pwm_ls = 1'b0; #1;
    chk("R11", "run gate_hs", gate_hs, 1'b1);
    chk("R11", "run gate_ls", gate_ls, 1'b0);
    chk("R10", "run comp_dis", comp_dis, 1'b0);
    pwm_hs = 1'b0; pwm_ls = 1'b1; #1;
    chk("R11", "low phase gate_hs", gate_hs, 1'b0);
    chk("R11", "low phase gate_ls", gate_ls, 1'b1);
  endtask

  task automatic t_limit();
    pwm_hs = 1'b1; pwm_ls = 1'b0; ls_over = 1'b1;
    oc_hs = 1'b1; #1;
    chk("R1", "oc gate_hs", gate_hs, 1'b0);
    chk("R1", "oc gate_ls", gate_ls, 1'b1);
    step(); oc_hs = 1'b0; #1;
    chk("R3", "held gate_ls", gate_ls, 1'b1);
    chk("R3", "held gate_hs", gate_hs, 1'b0);
    ls_over = 1'b0; step(); #1;
    chk("R3", "released gate_ls", gate_ls, 1'b0);
    chk("R2", "blocked gate_hs", gate_hs, 1'b0);
    strobe(1);
    chk("R2", "new period gate_hs", gate_hs, 1'b1);
  endtask

  task automatic t_blank();
    ls_over = 1'b1; fb_low = 1'b1;
    oc_pulse();
    tick(BLANK - 1);
    chk("R4", "one tick short", hiccup, 1'b0);
    fb_low = 1'b0; step(); fb_low = 1'b1; #1;
    tick(BLANK - 1);
    chk("R5", "after restart count", hiccup, 1'b0);
    tick(1);
    chk("R4", "entered hiccup", hiccup, 1'b1);
    chk("R6", "off gate_hs", gate_hs, 1'b0);
    chk("R6", "off gate_ls", gate_ls, 1'b0);
    chk("R6", "off comp_dis", comp_dis, 1'b1);
    chk("R6", "off ref_dis", ref_dis, 1'b1);
  endtask

  task automatic t_off();
    strobe(OFFC - 1);
    chk("R7", "off before last strobe", comp_dis, 1'b1);
    strobe(1);
    chk("R7", "retry comp_dis", comp_dis, 1'b0);
    chk("R7", "retry ref_dis", ref_dis, 1'b0);
    chk("R7", "retry hiccup", hiccup, 1'b1);
  endtask

  task automatic t_retry_fault();
    oc_pulse();
    tick(BLANK + 3);
    chk("R8", "blanked detect", comp_dis, 1'b0);
    chk("R8", "still hiccup", hiccup, 1'b1);
    strobe(RSTC - 1);
    chk("R8", "retry before last strobe", comp_dis, 1'b0);
    strobe(1);
    chk("R9", "fault back to off", comp_dis, 1'b1);
    chk("R9", "fault hiccup", hiccup, 1'b1);
  endtask

  task automatic t_retry_clean();
    fb_low = 1'b0; ls_over = 1'b0; pwm_hs = 1'b1; pwm_ls = 1'b0;
    strobe(OFFC);
    chk("R7", "second retry", hiccup, 1'b1);
    strobe(RSTC);
    chk("R9", "clean hiccup", hiccup, 1'b0);
    chk("R9", "clean comp_dis", comp_dis, 1'b0);
    chk("R9", "clean gate_hs", gate_hs, 1'b1);
  endtask

  task automatic t_enable();
    ls_over = 1'b1; pwm_hs = 1'b0; pwm_ls = 1'b0;
    oc_pulse();
    chk("R3", "hold before disable", gate_ls, 1'b1);
    enable = 1'b0; step(); #1;
    chk("R10", "disabled gate_ls", gate_ls, 1'b0);
    chk("R10", "disabled comp_dis", comp_dis, 1'b1);
    enable = 1'b1; step(); #1;
    chk("R10", "hold released gate_ls", gate_ls, 1'b0);
    fb_low = 1'b1;
    oc_pulse();
    tick(BLANK);
    chk("R4", "re-entered hiccup", hiccup, 1'b1);
    strobe(3);
    enable = 1'b0; step(); #1;
    chk("R10", "off to idle hiccup", hiccup, 1'b0);
    chk("R10", "off to idle ref_dis", ref_dis, 1'b1);
    enable = 1'b1; step(); #1;
    chk("R10", "idle to run hiccup", hiccup, 1'b0);
    chk("R10", "idle to run comp_dis", comp_dis, 1'b0);
    chk("R10", "idle to run gate_ls", gate_ls, 1'b0);
  endtask

  initial begin
    t_reset();
    t_run();
    t_limit();
    t_blank();
    t_off();
    t_retry_fault();
    t_retry_clean();
    t_enable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule